// File: doc/BRIEF.md
# Reduced RV32I Control Decoder

This block turns one 32-bit instruction word into the full set of control strobes for a small single-cycle datapath. It is purely combinational: the word goes in, and the control word settles in the same cycle. The datapath uses that control word to steer the register file write, the data memory access, the ALU function, the second ALU operand, branch and jump handling, and the writeback source.

Eleven instructions are recognised:
- the register-register ALU operations ADD, SUB, AND and OR;
- ADDI;
- the word load and store;
- the two equality branches;
- the two jumps.

Every other encoding, including other function codes under a known opcode, produces a control word that is all zero. An unknown word therefore never writes state or redirects the program counter.

Immediate extraction, the register file, the ALU and the next-PC arithmetic are handled by neighbouring blocks.

Top module: `rv_lite_decode`

## Requirements
- R1: Opcode 0110011 with funct7 0000000 decodes funct3 000 as ADD (alu_fn 000), 111 as AND (alu_fn 010) and 110 as OR (alu_fn 011). Opcode 0110011 with funct7 0100000 and funct3 000 decodes as SUB (alu_fn 001). Each of these asserts rf_wr_en, with opb_imm=0, wb_sel=00 and every other output 0.
- R2: Opcode 0010011 with funct3 000 (ADDI) asserts rf_wr_en and opb_imm, with alu_fn=000, wb_sel=00 and every other output 0.
- R3: Opcode 0000011 with funct3 010 (load word) asserts rf_wr_en, dm_rd_en and opb_imm, with alu_fn=000, wb_sel=01 and every other output 0.
- R4: Opcode 0100011 with funct3 010 (store word) asserts dm_wr_en and opb_imm, with alu_fn=000. rf_wr_en, dm_rd_en, is_branch, is_jump, wb_sel and br_on_ne are all 0.
- R5: Opcode 1100011 with funct3 000 (BEQ) or 001 (BNE) asserts is_branch, with alu_fn=001 (SUB) and opb_imm=0. br_on_ne is 0 for BEQ and 1 for BNE. No write enable is asserted.
- R6: Opcode 1101111 (JAL, any other bits) and opcode 1100111 with funct3 000 (JALR) assert is_jump and rf_wr_en, with wb_sel=10 and alu_fn=000. opb_imm is 0 for JAL and 1 for JALR. All other outputs are 0.
- R7: Any word not listed in R1 to R6 drives every output to 0. This covers unknown opcodes, other funct3 values and other funct7 values.
- R8: For any input, dm_wr_en and dm_rd_en are never both 1, is_branch and is_jump are never both 1, and wb_sel is never 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word to decode |
| rf_wr_en | output | 1 | Register file write enable |
| dm_wr_en | output | 1 | Data memory write enable |
| dm_rd_en | output | 1 | Data memory read enable |
| alu_fn | output | 3 | ALU function: 000 add, 001 sub, 010 and, 011 or |
| opb_imm | output | 1 | 0 selects rs2 as the second ALU operand, 1 selects the immediate |
| is_branch | output | 1 | Conditional branch |
| is_jump | output | 1 | JAL or JALR |
| wb_sel | output | 2 | Writeback source: 00 ALU, 01 load data, 10 PC+4 |
| br_on_ne | output | 1 | Branch condition: 0 taken when equal, 1 taken when not equal |

## Verification
The decoder holds no state, so a wrong decision shows at the ports in the same cycle the word is applied. The effect depends on the instruction class:
- A mis-decoded ALU operation appears as a wrong alu_fn for that encoding.
- A mis-decoded class appears as a stray enable, which in a datapath means a spurious write or a wrong PC redirect.

The bench sweeps every opcode against every funct3 value and several funct7 values, with varying register fields. The expected word for each input comes from an independent model of the requirements, so any single wrong entry is caught when that word is applied.

// File: rtl/rv_lite_decode.sv
module rv_lite_decode (
  input  logic [31:0] instr_i,
  output logic        rf_wr_en,
  output logic        dm_wr_en,
  output logic        dm_rd_en,
  output logic [2:0]  alu_fn,
  output logic        opb_imm,
  output logic        is_branch,
  output logic        is_jump,
  output logic [1:0]  wb_sel,
  output logic        br_on_ne
);
  localparam logic [6:0] OPC_ALU_R = 7'b0110011;
  localparam logic [6:0] OPC_ALU_I = 7'b0010011;
  localparam logic [6:0] OPC_LOAD  = 7'b0000011;
  localparam logic [6:0] OPC_STORE = 7'b0100011;
  localparam logic [6:0] OPC_BRNCH = 7'b1100011;
  localparam logic [6:0] OPC_JAL   = 7'b1101111;
  localparam logic [6:0] OPC_JALR  = 7'b1100111;

  localparam logic [2:0] FN_ADD = 3'b000;
  localparam logic [2:0] FN_SUB = 3'b001;
  localparam logic [2:0] FN_AND = 3'b010;
  localparam logic [2:0] FN_OR  = 3'b011;

  localparam logic [1:0] WB_ALU = 2'b00;
  localparam logic [1:0] WB_MEM = 2'b01;
  localparam logic [1:0] WB_PC4 = 2'b10;

  logic [6:0] opc;
  logic [2:0] f3;
  logic [6:0] f7;

  assign opc = instr_i[6:0];
  assign f3  = instr_i[14:12];
  assign f7  = instr_i[31:25];

  always_comb begin
    rf_wr_en  = 1'b0;
    dm_wr_en  = 1'b0;
    dm_rd_en  = 1'b0;
    alu_fn    = FN_ADD;
    opb_imm   = 1'b0;
    is_branch = 1'b0;
    is_jump   = 1'b0;
    wb_sel    = WB_ALU;
    br_on_ne  = 1'b0;
    unique case (opc)
      OPC_ALU_R: begin
        if (f7 == 7'b0000000) begin
          unique case (f3)
            3'b000:  begin rf_wr_en = 1'b1; alu_fn = FN_ADD; end
            3'b111:  begin rf_wr_en = 1'b1; alu_fn = FN_AND; end
            3'b110:  begin rf_wr_en = 1'b1; alu_fn = FN_OR;  end
            default: ;
          endcase
        end else if (f7 == 7'b0100000 && f3 == 3'b000) begin
          rf_wr_en = 1'b1;
          alu_fn   = FN_SUB;
        end
      end
      OPC_ALU_I: begin
        if (f3 == 3'b000) begin
          rf_wr_en = 1'b1;
          opb_imm  = 1'b1;
        end
      end
      OPC_LOAD: begin
        if (f3 == 3'b010) begin
          rf_wr_en = 1'b1;
          dm_rd_en = 1'b1;
          opb_imm  = 1'b1;
          wb_sel   = WB_MEM;
        end
      end
      OPC_STORE: begin
        if (f3 == 3'b010) begin
          dm_wr_en = 1'b1;
          opb_imm  = 1'b1;
        end
      end
      OPC_BRNCH: begin
        if (f3 == 3'b000 || f3 == 3'b001) begin
          is_branch = 1'b1;
          alu_fn    = FN_SUB;
          br_on_ne  = f3[0];
        end
      end
      OPC_JAL: begin
        is_jump  = 1'b1;
        rf_wr_en = 1'b1;
        wb_sel   = WB_PC4;
      end
      OPC_JALR: begin
        if (f3 == 3'b000) begin
          is_jump  = 1'b1;
          rf_wr_en = 1'b1;
          opb_imm  = 1'b1;
          wb_sel   = WB_PC4;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rv_lite_decode_chk.sv
module rv_lite_decode_chk (
  input logic [31:0] instr_i,
  input logic        rf_wr_en,
  input logic        dm_wr_en,
  input logic        dm_rd_en,
  input logic [2:0]  alu_fn,
  input logic        opb_imm,
  input logic        is_branch,
  input logic        is_jump,
  input logic [1:0]  wb_sel,
  input logic        br_on_ne
);
  logic known_opc;
  assign known_opc = instr_i[6:0] inside {7'b0110011, 7'b0010011, 7'b0000011,
                                          7'b0100011, 7'b1100011, 7'b1101111,
                                          7'b1100111};

  always_comb begin
    if (!$isunknown(instr_i)) begin
      p_mem_excl_r8: assert (!(dm_wr_en && dm_rd_en));
      p_flow_excl_r8: assert (!(is_branch && is_jump));
      p_wb_legal_r8: assert (wb_sel != 2'b11);
      p_unknown_idle_r7: assert (known_opc ||
        {rf_wr_en, dm_wr_en, dm_rd_en, is_branch, is_jump} == 5'b0);
      p_jump_link_r6: assert (!is_jump || (rf_wr_en && wb_sel == 2'b10));
      p_branch_nowrite_r5: assert (!is_branch ||
        (!rf_wr_en && !dm_wr_en && alu_fn == 3'b001));
      p_store_nowrite_r4: assert (!dm_wr_en || (!rf_wr_en && opb_imm));
      p_load_wb_r3: assert (!dm_rd_en || (rf_wr_en && wb_sel == 2'b01));
    end
  end
endmodule

bind rv_lite_decode rv_lite_decode_chk i_chk (.*);

// File: tb/test_rv_lite_decode.sv
module test_rv_lite_decode;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] instr_i;
  logic        rf_wr_en, dm_wr_en, dm_rd_en, opb_imm, is_branch, is_jump, br_on_ne;
  logic [2:0]  alu_fn;
  logic [1:0]  wb_sel;

  rv_lite_decode i_rv_lite_decode (
    .instr_i(instr_i), .rf_wr_en(rf_wr_en), .dm_wr_en(dm_wr_en),
    .dm_rd_en(dm_rd_en), .alu_fn(alu_fn), .opb_imm(opb_imm),
    .is_branch(is_branch), .is_jump(is_jump), .wb_sel(wb_sel),
    .br_on_ne(br_on_ne)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // {rf_wr_en, dm_wr_en, dm_rd_en, alu_fn[2:0], opb_imm, is_branch, is_jump, wb_sel[1:0], br_on_ne}
  function automatic logic [11:0] pack(bit rw, bit mw, bit mr, logic [2:0] fn,
                                       bit imm, bit br, bit jp, logic [1:0] wb, bit ne);
    return {rw, mw, mr, fn, imm, br, jp, wb, ne};
  endfunction

  function automatic logic [11:0] model(logic [31:0] w, output string req);
    logic [6:0] op = w[6:0];
    logic [2:0] f3 = w[14:12];
    logic [6:0] f7 = w[31:25];
    req = "R7";
    if (op == 7'h33 && f7 == 7'h00 && f3 == 3'd0) begin req = "R1"; return pack(1,0,0,3'd0,0,0,0,2'd0,0); end
    if (op == 7'h33 && f7 == 7'h20 && f3 == 3'd0) begin req = "R1"; return pack(1,0,0,3'd1,0,0,0,2'd0,0); end
    if (op == 7'h33 && f7 == 7'h00 && f3 == 3'd7) begin req = "R1"; return pack(1,0,0,3'd2,0,0,0,2'd0,0); end
    if (op == 7'h33 && f7 == 7'h00 && f3 == 3'd6) begin req = "R1"; return pack(1,0,0,3'd3,0,0,0,2'd0,0); end
    if (op == 7'h13 && f3 == 3'd0) begin req = "R2"; return pack(1,0,0,3'd0,1,0,0,2'd0,0); end
    if (op == 7'h03 && f3 == 3'd2) begin req = "R3"; return pack(1,0,1,3'd0,1,0,0,2'd1,0); end
    if (op == 7'h23 && f3 == 3'd2) begin req = "R4"; return pack(0,1,0,3'd0,1,0,0,2'd0,0); end
    if (op == 7'h63 && f3 == 3'd0) begin req = "R5"; return pack(0,0,0,3'd1,0,1,0,2'd0,0); end
    if (op == 7'h63 && f3 == 3'd1) begin req = "R5"; return pack(0,0,0,3'd1,0,1,0,2'd0,1); end
    if (op == 7'h6F) begin req = "R6"; return pack(1,0,0,3'd0,0,0,1,2'd2,0); end
    if (op == 7'h67 && f3 == 3'd0) begin req = "R6"; return pack(1,0,0,3'd0,1,0,1,2'd2,0); end
    return 12'h000;
  endfunction

  task automatic apply(logic [31:0] w, string tag);
    logic [11:0] exp, act;
    string req;
    @(posedge clk);
    instr_i = w;
    @(negedge clk);
    exp = model(w, req);
    act = {rf_wr_en, dm_wr_en, dm_rd_en, alu_fn, opb_imm, is_branch, is_jump, wb_sel, br_on_ne};
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s instr=%08h actual=%03h expected=%03h", req, tag, w, act, exp);
    end
    // R8 structural exclusions checked at the ports
    n_checks++;
    if ((dm_wr_en && dm_rd_en) || (is_branch && is_jump) || wb_sel == 2'b11) begin
      n_fail++;
      $display("FAIL R8 instr=%08h actual=%03h expected=exclusive enables", w, act);
    end
  endtask

  function automatic logic [31:0] enc(logic [6:0] f7, logic [2:0] f3, logic [6:0] op, int s);
    logic [4:0] a = 5'(s * 7 + 3);
    logic [4:0] b = 5'(s * 13 + 11);
    logic [4:0] c = 5'(s * 5 + 1);
    return {f7, a, b, f3, c, op};
  endfunction

  initial begin
    instr_i = 32'h0000_0000;
    // idle word: all-zero encoding must give an all-zero control word (R7)
    apply(32'h0000_0000, "R7 zero word");
    // one named check per variant
    apply(enc(7'h00, 3'd0, 7'h33, 1), "R1 ADD");
    apply(enc(7'h20, 3'd0, 7'h33, 2), "R1 SUB");
    apply(enc(7'h00, 3'd7, 7'h33, 3), "R1 AND");
    apply(enc(7'h00, 3'd6, 7'h33, 4), "R1 OR");
    apply(enc(7'h7F, 3'd0, 7'h13, 5), "R2 ADDI negative imm");
    apply(enc(7'h05, 3'd2, 7'h03, 6), "R3 LW");
    apply(enc(7'h7E, 3'd2, 7'h23, 7), "R4 SW");
    apply(enc(7'h00, 3'd0, 7'h63, 8), "R5 BEQ");
    apply(enc(7'h40, 3'd1, 7'h63, 9), "R5 BNE");
    apply(32'hFFFF_F06F, "R6 JAL");
    apply(enc(7'h00, 3'd0, 7'h67, 10), "R6 JALR");
    apply(enc(7'h20, 3'd7, 7'h33, 11), "R7 SUB-style funct7 on AND");
    apply(enc(7'h01, 3'd0, 7'h33, 12), "R7 other funct7");
    apply(32'hFFFF_FFFF, "R7 all ones");
    // sweep every opcode x funct3 x funct7 flavour
    for (int op = 0; op < 128; op++)
      for (int f3 = 0; f3 < 8; f3++)
        for (int k = 0; k < 3; k++) begin
          logic [6:0] f7 = (k == 0) ? 7'h00 : (k == 1) ? 7'h20 : 7'h01;
          apply(enc(f7, 3'(f3), 7'(op), op * 8 + f3 + k), "sweep");
        end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule